// File: doc/BRIEF.md
# MII Transmit Frame Encoder

This block turns a word-wide packet stream from an upstream client into the 64-bit data plus 8-bit control word that a PCS transmit client consumes. Each packet opens with a start block (start character, six preamble bytes and the start delimiter), continues with payload words, and closes with a terminate character placed in the lane just after the final payload byte. Idle characters fill every word that carries no packet content.

The downstream path can pause the encoder at any time. It does so with a valid level and an alignment-marker strobe. While the path is paused, and for one cycle after the pause ends, the output word holds its value and no upstream beat is accepted, so no byte is lost. Lane 0 (bits 7:0) is the first byte on the wire. If the upstream source runs dry in the middle of a packet, the encoder fills that word with error characters, because a packet cannot be paused on the line.

Top module: `mii_tx_frame_enc`

## Requirements
- R1: After reset the output word is all idle: 0x07 in every lane and every control bit at 1.
- R2: Lane i of the output (data bits 8i+7:8i) has control bit i. Lane i of an upstream beat appears unchanged in lane i of its output word, so upstream bits 7:0 are sent first.
- R3: A pending packet is preceded by one start word: lane 0 holds 0xFB with control 1, lanes 1 to 6 hold 0x55 and lane 7 holds 0xD5, all with control 0 (control word 0x01). The start word consumes no upstream beat.
- R4: A beat that is not the last beat of its packet produces one word that equals the beat's data with control word 0x00. The byte count field is ignored on such beats.
- R5: A last beat with byte count n from 1 to 7 produces one word in which lanes below n carry data with control 0, lane n carries 0xFD with control 1, and the lanes above n carry 0x07 with control 1. Upstream lanes at n and above are ignored.
- R6: A last beat with byte count 8 (or 0) produces a full data word. The next word has 0xFD in lane 0 and 0x07 in lanes 1 to 7, all with control 1.
- R7: A word holding a terminate is always followed by one complete idle word before the next start word.
- R8: A cycle inside a packet that is not paused and has no upstream beat produces an error word: 0xFE in every lane with all control bits at 1.
- R9: While the valid input is low or the marker input is high, and for one further cycle after that, the data and control outputs keep their previous values.
- R10: Upstream ready is low in every paused cycle. Beats are accepted only between the start word and the end of the packet, and each beat appears exactly once, in order.
- R11: With no packet pending, the encoder emits idle words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Upstream beat present |
| s_ready | output | 1 | Upstream beat accepted this cycle |
| s_data | input | 64 | Upstream bytes, lane 0 first |
| s_last | input | 1 | Beat is the last of its packet |
| s_nbytes | input | 4 | Valid bytes on a last beat (1 to 8; 0 means 8) |
| pcs_valid | input | 1 | Downstream path accepts words this cycle |
| pcs_am | input | 1 | Alignment-marker strobe; pauses the output |
| tx_d | output | 64 | MII data word |
| tx_c | output | 8 | MII control bits, one per lane |

## Verification
The bench builds the encoder with its default eight lanes. It sweeps packet lengths from 1 to 24 bytes, which reaches every byte count on a last beat, the terminate that spills into its own word, and packets of one, two and three beats. Valid dips and two-cycle marker strobes repeat at periods that are prime to each other, so pauses land on start, payload, terminate, gap and error words. Upstream holes of one and two cycles are placed inside packets to produce runs of error words.

// File: rtl/mii_enc_pkg.sv
package mii_enc_pkg;

    parameter int unsigned LANES_DEF = 8;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_PRE   = 8'h55;
    localparam logic [7:0] CH_SFD   = 8'hD5;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_ERR   = 8'hFE;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_TERM,
        ST_GAP
    } enc_state_e;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_START,
        WK_DATA,
        WK_DATA_TERM,
        WK_TERM,
        WK_ERROR
    } word_kind_e;

    typedef struct packed {
        logic       ctl;
        logic [7:0] dat;
    } mii_lane_t;

    function automatic mii_lane_t ctl_lane(input logic [7:0] ch);
        mii_lane_t l;
        l.ctl = 1'b1;
        l.dat = ch;
        return l;
    endfunction

    function automatic mii_lane_t data_lane(input logic [7:0] b);
        mii_lane_t l;
        l.ctl = 1'b0;
        l.dat = b;
        return l;
    endfunction

endpackage

// File: rtl/mii_enc_freeze.sv
module mii_enc_freeze (
    input  logic clk,
    input  logic rst,
    input  logic pcs_valid,
    input  logic pcs_am,
    output logic freeze,
    output logic advance
);
    logic pause_now;
    logic pause_q;

    assign pause_now = !pcs_valid || pcs_am;

    always_ff @(posedge clk) begin
        if (rst) pause_q <= 1'b0;
        else     pause_q <= pause_now;
    end

    assign freeze  = pause_now || pause_q;
    assign advance = !freeze;

    // R9
    trailing_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pause_now |=> freeze);

endmodule

// File: rtl/mii_enc_seq.sv
module mii_enc_seq
    import mii_enc_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned NBW   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             s_valid,
    input  logic             s_last,
    input  logic [NBW-1:0]   s_nbytes,
    output logic             s_ready,
    output word_kind_e       kind,
    output enc_state_e       state
);
    enc_state_e nxt;
    logic       full_last;

    assign full_last = (s_nbytes == '0) || (s_nbytes >= NBW'(LANES));

    always_comb begin
        nxt     = state;
        kind    = WK_IDLE;
        s_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (s_valid) begin
                    kind = WK_START;
                    nxt  = ST_DATA;
                end
            end
            ST_DATA: begin
                s_ready = advance;
                if (!s_valid) begin
                    kind = WK_ERROR;
                end else if (!s_last) begin
                    kind = WK_DATA;
                end else if (full_last) begin
                    kind = WK_DATA;
                    nxt  = ST_TERM;
                end else begin
                    kind = WK_DATA_TERM;
                    nxt  = ST_GAP;
                end
            end
            ST_TERM: begin
                kind = WK_TERM;
                nxt  = ST_GAP;
            end
            ST_GAP: begin
                kind = WK_IDLE;
                nxt  = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          state <= ST_IDLE;
        else if (advance) state <= nxt;
    end

    // R5
    last_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && s_last) |=> (state == ST_TERM || state == ST_GAP));

    // R10
    pause_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state));

endmodule

// File: rtl/mii_enc_build.sv
module mii_enc_build
    import mii_enc_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF,
    parameter int unsigned NBW   = $clog2(LANES + 1),
    localparam int unsigned DW   = LANES * 8
) (
    input  word_kind_e                  kind,
    input  logic [DW-1:0]               s_data,
    input  logic [NBW-1:0]              s_nbytes,
    output mii_lane_t [LANES-1:0]       word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (kind)
                WK_START: begin
                    if (i == 0)              word[i] = ctl_lane(CH_START);
                    else if (i == LANES - 1) word[i] = data_lane(CH_SFD);
                    else                     word[i] = data_lane(CH_PRE);
                end
                WK_DATA:  word[i] = data_lane(s_data[i*8 +: 8]);
                WK_DATA_TERM: begin
                    if (NBW'(i) < s_nbytes)       word[i] = data_lane(s_data[i*8 +: 8]);
                    else if (NBW'(i) == s_nbytes) word[i] = ctl_lane(CH_TERM);
                    else                          word[i] = ctl_lane(CH_IDLE);
                end
                WK_TERM: begin
                    if (i == 0) word[i] = ctl_lane(CH_TERM);
                    else        word[i] = ctl_lane(CH_IDLE);
                end
                WK_ERROR: word[i] = ctl_lane(CH_ERR);
                default:  word[i] = ctl_lane(CH_IDLE);
            endcase
        end
    end

endmodule

// File: rtl/mii_tx_frame_enc.sv
module mii_tx_frame_enc
    import mii_enc_pkg::*;
#(
    parameter  int unsigned LANES = LANES_DEF,
    localparam int unsigned DW    = LANES * 8,
    localparam int unsigned NBW   = $clog2(LANES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            s_valid,
    output logic            s_ready,
    input  logic [DW-1:0]   s_data,
    input  logic            s_last,
    input  logic [NBW-1:0]  s_nbytes,
    input  logic            pcs_valid,
    input  logic            pcs_am,
    output logic [DW-1:0]   tx_d,
    output logic [LANES-1:0] tx_c
);
    localparam logic [LANES-1:0] START_CTL = {{(LANES-1){1'b0}}, 1'b1};

    logic                   freeze;
    logic                   advance;
    word_kind_e             kind;
    enc_state_e             state;
    mii_lane_t [LANES-1:0]  word;
    mii_lane_t [LANES-1:0]  out_q;

    mii_enc_freeze u_freeze (
        .clk       (clk),
        .rst       (rst),
        .pcs_valid (pcs_valid),
        .pcs_am    (pcs_am),
        .freeze    (freeze),
        .advance   (advance)
    );

    mii_enc_seq #(.LANES(LANES), .NBW(NBW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .s_nbytes (s_nbytes),
        .s_ready  (s_ready),
        .kind     (kind),
        .state    (state)
    );

    mii_enc_build #(.LANES(LANES), .NBW(NBW)) u_build (
        .kind     (kind),
        .s_data   (s_data),
        .s_nbytes (s_nbytes),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LANES; i++) out_q[i] <= ctl_lane(CH_IDLE);
        end else if (advance) begin
            out_q <= word;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign tx_d[i*8 +: 8] = out_q[i].dat;
        assign tx_c[i]        = out_q[i].ctl;
    end

    // R9
    frozen_output_chk: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ($stable(tx_d) && $stable(tx_c)));

    // R3
    start_word_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && s_valid && advance) |=>
        (tx_c == START_CTL && tx_d[7:0] == CH_START && tx_d[DW-1 -: 8] == CH_SFD));

    // R4
    payload_word_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && s_valid && !s_last && advance) |=>
        (tx_c == '0 && tx_d == $past(s_data)));

    // R6
    spill_term_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TERM && advance) |=> (tx_c == '1 && tx_d[7:0] == CH_TERM));

    // R7
    gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && advance) |=> (tx_c == '1 && tx_d == {LANES{CH_IDLE}}));

    // R8
    underrun_err_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !s_valid && advance) |=> (tx_c == '1 && tx_d[7:0] == CH_ERR));

endmodule

// File: tb/mii_tx_frame_enc_tb.sv
module mii_tx_frame_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [63:0] s_data = '0;
    logic        s_last = 1'b0;
    logic [3:0]  s_nbytes = '0;
    logic        pcs_valid = 1'b0;
    logic        pcs_am = 1'b0;
    logic [63:0] tx_d;
    logic [7:0]  tx_c;

    always #5 clk = ~clk;

    mii_tx_frame_enc dut_i (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_nbytes  (s_nbytes),
        .pcs_valid (pcs_valid),
        .pcs_am    (pcs_am),
        .tx_d      (tx_d),
        .tx_c      (tx_c)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] bdata  [0:127];
    logic        blast  [0:127];
    logic [3:0]  bn     [0:127];
    int          bstall [0:127];
    int          nb = 0;

    logic [63:0] ed   [0:511];
    logic [7:0]  ec   [0:511];
    string       etag [0:511];
    int          ne = 0;

    localparam logic [63:0] IDLE_D = {8{8'h07}};

    task automatic push(input logic [63:0] d, input logic [7:0] c, input string t);
        ed[ne] = d; ec[ne] = c; etag[ne] = t; ne++;
    endtask

    task automatic chkw(input string t, input logic [63:0] xd, input logic [7:0] xc);
        n_chk++;
        if (tx_d !== xd || tx_c !== xc) begin
            n_bad++;
            $display("FAIL %s: got d=%h c=%h expected d=%h c=%h", t, tx_d, tx_c, xd, xc);
        end
    endtask

    function automatic logic [7:0] bval(input int p, input int i);
        return 8'((p * 37 + i * 11 + 1) & 255);
    endfunction

    initial begin
        logic [63:0] held_d;
        logic [7:0]  held_c;
        logic        adv_prev, hs_prev, raw_prev, hold_m, raw, fz;
        int          e, bi, cyc;

        // build stimulus and expected word stream
        for (int p = 0; p < 24; p++) begin
            int len = p + 1;
            int nbt = (len + 7) / 8;
            push({8'hD5, {6{8'h55}}, 8'hFB}, 8'h01, "R3");
            for (int b = 0; b < nbt; b++) begin
                int n = (b == nbt - 1) ? len - 8 * b : 8;
                logic [63:0] bd, xd;
                logic [7:0]  xc;
                bstall[nb] = (b == 1) ? (p % 3) : 0;
                for (int k = 0; k < bstall[nb]; k++) push({8{8'hFE}}, 8'hFF, "R8");
                for (int j = 0; j < 8; j++) begin
                    bd[j*8 +: 8] = (j < n) ? bval(p, b * 8 + j) : 8'hAA;
                    if (b == nbt - 1 && n < 8) begin
                        xd[j*8 +: 8] = (j < n) ? bval(p, b * 8 + j) : (j == n) ? 8'hFD : 8'h07;
                        xc[j]        = (j >= n);
                    end else begin
                        xd[j*8 +: 8] = bval(p, b * 8 + j);
                        xc[j]        = 1'b0;
                    end
                end
                bdata[nb] = bd;
                blast[nb] = (b == nbt - 1);
                bn[nb]    = (b == nbt - 1) ? 4'(n) : 4'd3;
                nb++;
                if (b == nbt - 1 && n < 8) push(xd, xc, "R5");
                else                       push(xd, xc, (b == 0) ? "R2" : "R4");
                if (b == nbt - 1 && n == 8) push({{7{8'h07}}, 8'hFD}, 8'hFF, "R6");
            end
            push(IDLE_D, 8'hFF, "R7");
        end
        for (int k = 0; k < 4; k++) push(IDLE_D, 8'hFF, "R11");

        // reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chkw("R1", IDLE_D, 8'hFF);
        rst = 1'b0;

        held_d = tx_d; held_c = tx_c;
        adv_prev = 1'b0; hs_prev = 1'b0; raw_prev = 1'b0;
        e = 0; bi = 0; cyc = 0;

        while (e < ne && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            if (cyc > 0) begin
                if (adv_prev) begin
                    chkw(etag[e], ed[e], ec[e]);
                    e++;
                end else begin
                    chkw("R9", held_d, held_c);
                end
            end
            held_d = tx_d; held_c = tx_c;
            if (hs_prev) bi++;

            hold_m    = raw_prev;
            pcs_valid = !(cyc < 2 || cyc % 13 == 7 || cyc % 13 == 8);
            pcs_am    = (cyc % 31 == 20) || (cyc % 31 == 21);
            raw       = !pcs_valid || pcs_am;
            fz        = raw || hold_m;
            raw_prev  = raw;

            if (bi < nb && bstall[bi] == 0) begin
                s_valid  = 1'b1;
                s_data   = bdata[bi];
                s_last   = blast[bi];
                s_nbytes = bn[bi];
            end else begin
                s_valid  = 1'b0;
                s_data   = '0;
                s_last   = 1'b0;
                s_nbytes = '0;
                if (bi < nb && !fz) bstall[bi]--;
            end

            #1;
            if (fz) begin
                n_chk++;
                if (s_ready !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R10: s_ready=%b expected 0 while paused", s_ready);
                end
            end
            hs_prev  = s_valid && s_ready;
            adv_prev = !fz;
            cyc++;
        end

        if (e < ne) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: %0d words seen expected %0d", e, ne);
        end
        n_chk++;
        if (bi != nb) begin
            n_bad++;
            $display("FAIL R10: beats taken %0d expected %0d", bi, nb);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule